// File: doc/BRIEF.md
# External Interrupt Controller

This block turns four external interrupt pins and one active-low non-maskable interrupt pin into request lines for a processor. Every pin first passes through a two-stage synchronizer clocked by the system clock. Each of the four normal pins then goes to its own channel. A channel is set to edge or level triggering, and its polarity is set to rising/high or falling/low. The channel records detected events in a status bit. A per-pin mask gates that status bit onto the pin's own request output. The NMI pin drives a separate request, and a single enable bit gates it.

Software reaches the block through a small write/read register port. A write takes effect on the clock edge where `wr_i` is high. Reads are combinational from `addr_i`. The mask is never written directly. It is set through one register and cleared through another, and both act only on the bits written as one. Status bits are cleared the same way.

Each channel is a two-state machine with states `CH_IDLE` (no event recorded) and `CH_PEND` (event recorded). In edge mode the transition `HIT` (a qualifying edge of the synchronized sample) moves `CH_IDLE` to `CH_PEND`. The transition `CLEAR` (a clear write with no simultaneous hit) moves `CH_PEND` back to `CH_IDLE`. In all other edge-mode cases the state holds. In level mode the transition `TRACK` applies on every cycle: the next state is `CH_PEND` when the synchronized input is at its active level, and `CH_IDLE` otherwise.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all irq_o bits, nmi_irq_o and every readable register (mode, polarity, mask, status, NMI control) are zero.
- R2: A pin change driven before clock edge k first shows on status and irq_o after edge k+2. It is not visible after edge k+1.
- R3: With mode bit 0 (edge), polarity bit 1 selects rising edges and polarity bit 0 selects falling edges. One qualifying edge sets the status bit once, and the bit stays set until it is cleared.
- R4: With mode bit 1 (level), the status bit follows the synchronized pin: high is active when polarity is 1, low is active when polarity is 0. A status-clear write has no lasting effect while the level is active.
- R5: irq_o[i] is high exactly when status bit i and mask bit i are both set. The pins do not affect one another.
- R6: Writing the mask-set register sets every mask bit written as 1. Bits written as 0 leave their mask bits unchanged.
- R7: Writing the mask-clear register clears every mask bit written as 1. Bits written as 0 leave their mask bits unchanged.
- R8: Writing the status-clear register clears the edge-mode status bits written as 1, and zero bits leave status unchanged. A qualifying edge in the same cycle as the clear keeps the bit set.
- R9: nmi_irq_o is high when NMI control bit 0 is set and the synchronized nmi_n_i is low, with the same latency as R2.
- R10: Register addresses: 0 mode, 1 polarity, 2 mask-set, 3 mask-clear, 4 mask read, 5 status, 6 status-clear, 7 NMI control (bit 0). Bit i of each register belongs to pin i. Mode, polarity and NMI control read back what was written. The write-only addresses 2, 3 and 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | External interrupt pins, not synchronized |
| nmi_n_i | input | 1 | Non-maskable interrupt pin, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 4 | Register write data |
| rdata_o | output | 4 | Register read data |
| irq_o | output | 4 | Per-pin interrupt requests |
| nmi_irq_o | output | 1 | Non-maskable interrupt request |

## Verification
The bench sweeps every pin through all four mode and polarity combinations. It pulses each pin to its active level and back. This separates a sticky edge record from a level that tracks the pin, and a rising trigger from a falling one. Sampling one edge before and at the expected latency catches a synchronizer that is too short or too deep. Mask-set and mask-clear writes with mixed and all-zero patterns show the mask bits acting independently. A clear timed onto the same edge as a new event decides which one wins. The NMI path is driven with its enable both off and on.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int NCH    = 4;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_POL  = 3'd1,
        A_MSET = 3'd2,
        A_MCLR = 3'd3,
        A_MASK = 3'd4,
        A_STAT = 3'd5,
        A_SCLR = 3'd6,
        A_NMI  = 3'd7
    } eic_addr_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/eic_chan.sv
module eic_chan
    import eic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic lvl_mode_i,
    input  logic pol_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic pend_o,
    output logic irq_o
);
    ch_state_e state_q, state_d;
    logic      prev_q;
    logic      hit;
    logic      act_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign hit     = pol_i ? (smp_i & ~prev_q) : (~smp_i & prev_q);
    assign act_lvl = pol_i ? smp_i : ~smp_i;

    always_comb begin
        state_d = state_q;
        if (lvl_mode_i) begin
            state_d = act_lvl ? CH_PEND : CH_IDLE;           // TRACK
        end else begin
            unique case (state_q)
                CH_IDLE: if (hit)            state_d = CH_PEND;  // HIT
                CH_PEND: if (clr_i && !hit)  state_d = CH_IDLE;  // CLEAR
                default:                     state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == CH_PEND);
        irq_o  = pend_o & mask_i;
    end

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode_i && state_q == CH_PEND && !clr_i) |=> state_q == CH_PEND); // R3
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_mode_i |=> (state_q == CH_PEND) == $past(pol_i ? smp_i : !smp_i)); // R4
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode_i && clr_i && hit) |=> state_q == CH_PEND); // R8
endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NCH-1:0]    wdata_i,
    input  logic [NCH-1:0]    stat_i,
    output logic [NCH-1:0]    mode_o,
    output logic [NCH-1:0]    pol_o,
    output logic [NCH-1:0]    mask_o,
    output logic              nmi_en_o,
    output logic [NCH-1:0]    clr_o,
    output logic [NCH-1:0]    rdata_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o   <= '0;
            pol_o    <= '0;
            mask_o   <= '0;
            nmi_en_o <= 1'b0;
        end else if (wr_i) begin
            unique case (eic_addr_e'(addr_i))
                A_MODE:  mode_o   <= wdata_i;
                A_POL:   pol_o    <= wdata_i;
                A_MSET:  mask_o   <= mask_o | wdata_i;
                A_MCLR:  mask_o   <= mask_o & ~wdata_i;
                A_NMI:   nmi_en_o <= wdata_i[0];
                default: ;
            endcase
        end
    end

    assign clr_o = (wr_i && eic_addr_e'(addr_i) == A_SCLR) ? wdata_i : '0;

    always_comb begin
        rdata_o = '0;
        unique case (eic_addr_e'(addr_i))
            A_MODE:  rdata_o = mode_o;
            A_POL:   rdata_o = pol_o;
            A_MASK:  rdata_o = mask_o;
            A_STAT:  rdata_o = stat_i;
            A_NMI:   rdata_o = {{(NCH-1){1'b0}}, nmi_en_o};
            default: rdata_o = '0;
        endcase
    end

    AST_MSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MSET) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R6
    AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_MCLR) |=> ((mask_o & $past(wdata_i)) == '0)); // R7
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pin_i,
    input  logic              nmi_n_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NCH-1:0]    wdata_i,
    output logic [NCH-1:0]    rdata_o,
    output logic [NCH-1:0]    irq_o,
    output logic              nmi_irq_o
);
    localparam int SW = NCH + 1;

    logic [SW-1:0]  smp;
    logic [NCH-1:0] mode, pol, mask, clr, stat;
    logic           nmi_en;
    logic           nmi_q;

    eic_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({nmi_n_i, pin_i}),
        .q_o   (smp)
    );

    eic_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .stat_i   (stat),
        .mode_o   (mode),
        .pol_o    (pol),
        .mask_o   (mask),
        .nmi_en_o (nmi_en),
        .clr_o    (clr),
        .rdata_o  (rdata_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        eic_chan u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_i      (smp[i]),
            .lvl_mode_i (mode[i]),
            .pol_i      (pol[i]),
            .clr_i      (clr[i]),
            .mask_i     (mask[i]),
            .pend_o     (stat[i]),
            .irq_o      (irq_o[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi_en & ~smp[NCH];
    end

    assign nmi_irq_o = nmi_q;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~mask) == '0)); // R5
    AST_NMI_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_en && !nmi_irq_o) |=> !nmi_irq_o); // R9
endmodule

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = 4'h0;
    logic       nmi_n = 1'b1;
    logic       wr = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [3:0] wdata = 4'h0;
    logic [3:0] rdata, irq;
    logic       nmi_irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .nmi_n_i(nmi_n),
        .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .nmi_irq_o(nmi_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [3:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [3:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] r;
        cyc(3);
        chk("R1 irq", irq, 0);
        chk("R1 nmi", nmi_irq, 0);
        rst_n = 1'b1;
        cyc(1);
        for (int a = 0; a < 8; a++) begin
            rreg(3'(a), r);
            chk("R1 reg", r, 0);
        end

        // sweep pins x mode x polarity
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 2; m++) begin
                for (int q = 0; q < 2; q++) begin
                    logic [3:0] b;
                    b = 4'(1 << p);
                    pins[p] = (q == 0);
                    cyc(4);
                    wreg(3'd0, m ? b : 4'h0);
                    wreg(3'd1, q ? b : 4'h0);
                    wreg(3'd3, 4'hF);
                    wreg(3'd2, b);
                    wreg(3'd6, 4'hF);
                    rreg(3'd5, r);
                    chk("R3/R4 idle status", r, 0);
                    pins[p] = (q == 1);
                    cyc(2);
                    chk("R2 too early", irq, 0);
                    cyc(1);
                    chk(m ? "R2 R4 R5 level irq" : "R2 R3 R5 edge irq", irq, b);
                    pins[p] = (q == 0);
                    cyc(4);
                    rreg(3'd5, r);
                    if (m == 0) begin
                        chk("R3 edge sticky", r, b);
                        wreg(3'd6, ~b);
                        rreg(3'd5, r);
                        chk("R8 zero bits no effect", r, b);
                        wreg(3'd6, b);
                        rreg(3'd5, r);
                        chk("R8 clear", r, 0);
                    end else begin
                        chk("R4 level released", r, 0);
                        pins[p] = (q == 1);
                        cyc(4);
                        wreg(3'd6, b);
                        cyc(1);
                        rreg(3'd5, r);
                        chk("R4 clear no lasting effect", r, b);
                        pins[p] = (q == 0);
                        cyc(4);
                        rreg(3'd5, r);
                        chk("R4 level tracks", r, 0);
                    end
                end
            end
        end

        // mask set/clear
        wreg(3'd0, 4'h0);
        wreg(3'd1, 4'hF);
        pins = 4'h0;
        cyc(4);
        wreg(3'd6, 4'hF);
        pins = 4'hF;
        cyc(4);
        rreg(3'd5, r);
        chk("R3 all rising", r, 4'hF);
        wreg(3'd3, 4'hF);
        chk("R5 all masked", irq, 0);
        wreg(3'd2, 4'h5);
        chk("R6 R5 mset 5", irq, 4'h5);
        wreg(3'd2, 4'h0);
        chk("R6 mset zero", irq, 4'h5);
        rreg(3'd4, r);
        chk("R10 mask read", r, 4'h5);
        wreg(3'd3, 4'h1);
        chk("R7 mclr 1", irq, 4'h4);
        wreg(3'd3, 4'h0);
        chk("R7 mclr zero", irq, 4'h4);

        // clear colliding with new edge
        pins[0] = 1'b0;
        cyc(4);
        pins[0] = 1'b1;
        cyc(2);
        wreg(3'd6, 4'h1);
        rreg(3'd5, r);
        chk("R8 edge beats clear", r, 4'hF);
        wreg(3'd6, 4'hF);
        cyc(3);
        rreg(3'd5, r);
        chk("R3 set once", r, 0);

        // NMI
        wreg(3'd7, 4'h1);
        cyc(4);
        chk("R9 pin high", nmi_irq, 0);
        nmi_n = 1'b0;
        cyc(2);
        chk("R9 too early", nmi_irq, 0);
        cyc(1);
        chk("R9 nmi asserted", nmi_irq, 1);
        rreg(3'd7, r);
        chk("R10 nmi ctl read", r, 4'h1);
        wreg(3'd7, 4'h0);
        cyc(1);
        chk("R9 disabled", nmi_irq, 0);
        nmi_n = 1'b1;

        // readback
        wreg(3'd0, 4'hA);
        rreg(3'd0, r);
        chk("R10 mode read", r, 4'hA);
        wreg(3'd1, 4'h5);
        rreg(3'd1, r);
        chk("R10 pol read", r, 4'h5);
        rreg(3'd2, r);
        chk("R10 mset reads 0", r, 0);
        rreg(3'd3, r);
        chk("R10 mclr reads 0", r, 0);
        rreg(3'd6, r);
        chk("R10 sclr reads 0", r, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule